// File: doc/BRIEF.md
# Cartridge Bank Switch Controller

This block sits between a CPU's write path and a cartridge's ROM and RAM. Writes into the lower half of the 16-bit address space do not reach any memory. They land in four small control registers, one per 8 KiB slice of that region. From those registers the block builds three values: the 16 KiB ROM bank shown in the upper ROM window, the 8 KiB external RAM bank, and a flag that opens external RAM to the CPU.

A 2-bit auxiliary register has two uses, chosen by a 1-bit layout select:
- With the select at 0, the auxiliary register supplies ROM bank bits 6:5.
- With the select at 1, it picks the RAM bank instead.

A zero written to the 5-bit primary bank register is stored as 1. The ROM bank is wrapped into the number of ROM banks fitted, which arrives on a port. The auxiliary value is wrapped into the number of RAM banks when it is written.

The block also gates the external RAM data path. While RAM is closed:
- reads through it return 0xFF;
- writes into the 0xA000–0xBFFF window raise no RAM write strobe.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset RAM is closed, the primary register is 1, the auxiliary register is 0 and the layout select is 0, so romBank is 1 (with at least 2 ROM banks) and ramBank is 0.
- R2: A write with addr[15:13]=000 opens RAM when wrData[3:0] is 0xA and closes it for any other value; upper data bits are ignored.
- R3: A write with addr[15:13]=001 loads wrData[4:0] into the primary bank register; the value 0 is stored as 1.
- R4: A write with addr[15:13]=010 loads wrData[1:0] modulo ramBankCount into the auxiliary register; with ramBankCount 0 it stores 0.
- R5: A write with addr[15:13]=011 loads the layout select from wrData[0].
- R6: With the layout select at 0, romBank is primary OR (auxiliary << 5) before wrapping, and ramBank is 0.
- R7: With the layout select at 1, romBank is the primary register alone before wrapping, and ramBank is the auxiliary register.
- R8: romBank is the composed number modulo romBankCount; with romBankCount 0 it is 0.
- R9: While RAM is closed, extRdData is 0xFF and ramWrEn stays low. While it is open, extRdData equals ramRdData, and ramWrEn is high during a write with addr[15:13]=101.
- R10: Cycles with wrEn low, and writes with addr[15]=1, leave all four registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 16 | CPU address |
| wrData | input | 8 | CPU write data |
| romBankCount | input | 8 | Number of 16 KiB ROM banks fitted |
| ramBankCount | input | 3 | Number of 8 KiB RAM banks fitted |
| ramRdData | input | 8 | Read data from external RAM |
| romBank | output | 7 | Bank shown in the 0x4000–0x7FFF window |
| ramBank | output | 2 | Selected external RAM bank |
| ramEnabled | output | 1 | External RAM open to the CPU |
| ramWrEn | output | 1 | Gated write strobe toward external RAM |
| extRdData | output | 8 | External RAM read data as seen by the CPU |

## Verification
Register writes are tried in both layouts, so that a nonzero auxiliary value visibly lands either in ROM bits 6:5 or on ramBank. Bank counts that are powers of two are used alongside counts that are not, and a zero count is also tried; this separates true modulo wrapping from plain bit masking. Enable-register values with 0xA in the low nibble are mixed with values that differ only in the upper nibble, which shows that only the nibble decides. Writes above 0x7FFF and address-only cycles with the strobe low show that the registers do not change.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  // Region codes taken from addr[15:13]
  localparam logic [2:0] REG_RAMEN = 3'b000;
  localparam logic [2:0] REG_LOW   = 3'b001;
  localparam logic [2:0] REG_AUX   = 3'b010;
  localparam logic [2:0] REG_MODE  = 3'b011;
  localparam logic [2:0] WIN_RAM   = 3'b101;

  localparam logic [3:0] RAM_KEY   = 4'hA;

  // Strobes from decode to datapath
  typedef struct packed {
    logic ldRamEn;
    logic ldLow;
    logic ldAux;
    logic ldMode;
    logic ramWin;
  } bankStrobes_t;

endpackage

// File: rtl/bank_wrap.sv
module bank_wrap #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] count,
  output logic [W-1:0] wrapped
);
  always_comb begin
    if (count == '0) wrapped = '0;
    else             wrapped = value % count;
  end
endmodule

// File: rtl/cart_bank_decode.sv
module cart_bank_decode
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobes_t      strobes
);
  logic [2:0] region;
  assign region = addr[ADDR_W-1 -: 3];

  always_comb begin
    strobes        = '0;
    strobes.ramWin = wrEn && (region == WIN_RAM);
    if (wrEn) begin
      unique case (region)
        REG_RAMEN: strobes.ldRamEn = 1'b1;
        REG_LOW:   strobes.ldLow   = 1'b1;
        REG_AUX:   strobes.ldAux   = 1'b1;
        REG_MODE:  strobes.ldMode  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_datapath.sv
module cart_bank_datapath
  import cart_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOW_W  = 5,
  parameter int AUX_W  = 2,
  localparam int ROM_W    = LOW_W + AUX_W,
  localparam int ROMCNT_W = ROM_W + 1,
  localparam int RAMCNT_W = AUX_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStrobes_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ROMCNT_W-1:0] romBankCount,
  input  logic [RAMCNT_W-1:0] ramBankCount,
  input  logic [DATA_W-1:0]   ramRdData,
  output logic [ROM_W-1:0]    romBank,
  output logic [AUX_W-1:0]    ramBank,
  output logic                ramEnabled,
  output logic                ramWrEn,
  output logic [DATA_W-1:0]   extRdData
);
  logic                ramEnReg;
  logic [LOW_W-1:0]    lowReg;
  logic [AUX_W-1:0]    auxReg;
  logic                modeReg;
  logic [LOW_W-1:0]    lowNext;
  logic [RAMCNT_W-1:0] auxWrapped;
  logic [ROMCNT_W-1:0] romComposed;
  logic [ROMCNT_W-1:0] romWrapped;

  assign lowNext = (wrData[LOW_W-1:0] == '0) ? LOW_W'(1) : wrData[LOW_W-1:0];

  bank_wrap #(.W(RAMCNT_W)) uAuxWrap (
    .value  ({1'b0, wrData[AUX_W-1:0]}),
    .count  (ramBankCount),
    .wrapped(auxWrapped)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramEnReg <= 1'b0;
      lowReg   <= LOW_W'(1);
      auxReg   <= '0;
      modeReg  <= 1'b0;
    end else begin
      if (strobes.ldRamEn) ramEnReg <= (wrData[3:0] == RAM_KEY);
      if (strobes.ldLow)   lowReg   <= lowNext;
      if (strobes.ldAux)   auxReg   <= auxWrapped[AUX_W-1:0];
      if (strobes.ldMode)  modeReg  <= wrData[0];
    end
  end

  always_comb begin
    if (modeReg) begin
      romComposed = ROMCNT_W'(lowReg);
      ramBank     = auxReg;
    end else begin
      romComposed = {1'b0, auxReg, lowReg};
      ramBank     = '0;
    end
  end

  bank_wrap #(.W(ROMCNT_W)) uRomWrap (
    .value  (romComposed),
    .count  (romBankCount),
    .wrapped(romWrapped)
  );

  assign romBank    = romWrapped[ROM_W-1:0];
  assign ramEnabled = ramEnReg;
  assign ramWrEn    = strobes.ramWin && ramEnReg;
  assign extRdData  = ramEnReg ? ramRdData : {DATA_W{1'b1}};

  a_r3_low_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lowReg != '0);

  a_r2_enable_key: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ldRamEn |=> ramEnabled == ($past(wrData[3:0]) == RAM_KEY));

  a_r4_aux_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldAux && ramBankCount != '0) |=> (RAMCNT_W'(auxReg) < $past(ramBankCount)));

  a_r5_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ldMode |=> $stable(modeReg));

  a_r8_rom_in_range: assert property (@(posedge clk) disable iff (!rstN)
    romBankCount != '0 |-> ROMCNT_W'(romBank) < romBankCount);

  a_r9_closed_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !ramEnabled |-> (!ramWrEn && extRdData == {DATA_W{1'b1}}));

  a_r6_ram_zero_layout0: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldMode && !wrData[0]) |=> ramBank == '0);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LOW_W  = 5,
  parameter int AUX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [LOW_W+AUX_W:0]     romBankCount,
  input  logic [AUX_W:0]           ramBankCount,
  input  logic [DATA_W-1:0]        ramRdData,
  output logic [LOW_W+AUX_W-1:0]   romBank,
  output logic [AUX_W-1:0]         ramBank,
  output logic                     ramEnabled,
  output logic                     ramWrEn,
  output logic [DATA_W-1:0]        extRdData
);
  bankStrobes_t strobes;

  cart_bank_decode #(.ADDR_W(ADDR_W)) uDecode (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobes(strobes)
  );

  cart_bank_datapath #(
    .DATA_W(DATA_W), .LOW_W(LOW_W), .AUX_W(AUX_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .romBankCount(romBankCount),
    .ramBankCount(ramBankCount),
    .ramRdData   (ramRdData),
    .romBank     (romBank),
    .ramBank     (ramBank),
    .ramEnabled  (ramEnabled),
    .ramWrEn     (ramWrEn),
    .extRdData   (extRdData)
  );

  a_r10_high_half_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || addr[ADDR_W-1]) |-> !(strobes.ldRamEn || strobes.ldLow || strobes.ldAux || strobes.ldMode));
endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RD_PATTERN = 8'h5C;

  typedef struct {
    logic [6:0] rom;
    logic [1:0] ram;
    logic       en;
    string      tag;
  } expItem_t;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wrData = 0;
  logic [7:0]  romCnt = 8'd128;
  logic [2:0]  ramCnt = 3'd4;
  logic [6:0]  romBank;
  logic [1:0]  ramBank;
  logic        ramEnabled, ramWrEn;
  logic [7:0]  extRdData;

  int checks = 0, errors = 0;
  expItem_t sbQ[$];
  bit done = 0;

  // Reference model state
  logic [4:0] mLow = 5'd1;
  logic [1:0] mAux = 2'd0;
  logic       mMode = 0, mEn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .romBankCount(romCnt), .ramBankCount(ramCnt), .ramRdData(RD_PATTERN),
    .romBank(romBank), .ramBank(ramBank), .ramEnabled(ramEnabled),
    .ramWrEn(ramWrEn), .extRdData(extRdData));

  function automatic logic [6:0] modelRom();
    logic [7:0] c;
    c = mMode ? {3'b0, mLow} : {1'b0, mAux, mLow};
    if (romCnt == 0) return 7'd0;
    c = c % romCnt;
    return c[6:0];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(string tag);
    expItem_t it;
    it.rom = modelRom();
    it.ram = mMode ? mAux : 2'd0;
    it.en  = mEn;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Driver: one write (or strobe-low cycle) per call
  task automatic doCycle(input logic we, input logic [15:0] a, input logic [7:0] d, input string tag);
    logic [2:0] cnt;
    @(negedge clk);
    wrEn = we; addr = a; wrData = d;
    #1;
    // R9: write strobe gating is combinational on the current cycle
    check({tag, " R9 ramWrEn"}, ramWrEn, we && a[15:13] == 3'b101 && mEn);
    if (we) begin
      case (a[15:13])
        3'b000: mEn = (d[3:0] == 4'hA);
        3'b001: mLow = (d[4:0] == 0) ? 5'd1 : d[4:0];
        3'b010: begin cnt = (ramCnt == 0) ? 3'd0 : {1'b0, d[1:0]} % ramCnt; mAux = cnt[1:0]; end
        3'b011: mMode = d[0];
        default: ;
      endcase
    end
    pushExp(tag);
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
  endtask

  // Monitor: compare after each edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk); #1;
      while (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        check({it.tag, " romBank"}, romBank, it.rom);
        check({it.tag, " ramBank"}, ramBank, it.ram);
        check({it.tag, " ramEnabled"}, ramEnabled, it.en);
        check({it.tag, " extRdData R9"}, extRdData, it.en ? RD_PATTERN : 8'hFF);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    doCycle(0, 16'h0000, 8'h00, "R1 reset");
    doCycle(1, 16'h0000, 8'h0A, "R2 open");
    doCycle(1, 16'h1FFF, 8'h00, "R2 close");
    doCycle(1, 16'h1000, 8'hFA, "R2 upper nibble ignored");
    doCycle(1, 16'h0123, 8'hA5, "R2 nibble not A");
    doCycle(1, 16'h0000, 8'h3A, "R2 reopen");
    doCycle(1, 16'h2000, 8'h00, "R3 zero to one");
    doCycle(1, 16'h3FFF, 8'h1F, "R3 max");
    doCycle(1, 16'h2ABC, 8'hE3, "R3 five bits");
    doCycle(1, 16'h4000, 8'h03, "R6 aux into rom");
    doCycle(1, 16'h6000, 8'h01, "R5 R7 layout one");
    doCycle(1, 16'h5FFF, 8'hFE, "R7 aux two");
    doCycle(1, 16'h7FFF, 8'hFE, "R5 R6 layout zero");
    ramCnt = 3'd3;
    doCycle(1, 16'h4000, 8'h03, "R4 modulo three");
    ramCnt = 3'd0;
    doCycle(1, 16'h4000, 8'h02, "R4 zero count");
    ramCnt = 3'd4;
    doCycle(1, 16'h4000, 8'h02, "R4 aux two");
    doCycle(1, 16'h6000, 8'h01, "R7 layout one again");
    doCycle(1, 16'h6000, 8'h00, "R6 back to zero");
    romCnt = 8'd32;
    doCycle(0, 16'h0000, 8'h00, "R8 mask 32");
    doCycle(1, 16'h2000, 8'h1F, "R8 low max");
    romCnt = 8'd20;
    doCycle(0, 16'h0000, 8'h00, "R8 modulo 20");
    romCnt = 8'd0;
    doCycle(0, 16'h0000, 8'h00, "R8 zero count");
    romCnt = 8'd128;
    doCycle(1, 16'h8000, 8'h00, "R10 high half");
    doCycle(1, 16'hFF00, 8'h0A, "R10 top page");
    doCycle(0, 16'h2000, 8'h05, "R10 strobe low");
    doCycle(0, 16'h0000, 8'h00, "R10 strobe low enable");
    doCycle(1, 16'hA000, 8'h77, "R9 open write");
    doCycle(1, 16'hBFFF, 8'h11, "R9 open write top");
    doCycle(1, 16'h0000, 8'h00, "R9 close");
    doCycle(1, 16'hA000, 8'h77, "R9 closed write");
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    #2;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule